// File: doc/BRIEF.md
# Dual GPIO Port Interrupt Controller

The block provides two 8-bit general-purpose I/O ports, A and B, behind one byte-wide register bus. Each port has an output data register and a direction register that together drive the pads. Its pad inputs pass through a two-flop synchroniser and, pin by pin, an optional debounce filter. An interrupt detector follows. For each pin, software chooses level or edge detection and the active polarity.

Edge events are latched in a raw status register until software writes a one to the matching bit of the end-of-interrupt register. Level-mode status simply follows the pin. The masked status is the raw status gated by a per-pin enable. The single interrupt output is high whenever any enabled pin of either port has status. An interrupt handler reads the masked status of both ports to find the pin that fired.

The register bus is plain control access: a write takes effect at the clock edge where `bus_wr` is high, and reads are combinational from `bus_addr`. No data stream crosses the block, so there is no valid/ready handshake.

Top module: `gpio_dual_irq`

## Requirements
- R1: After reset every register is zero. All pins are inputs (`pa_oe`/`pb_oe` low), detection is level-low on every pin, all enables are off and `irq` is low. The raw status then reads as the inverse of the synchronised inputs.
- R2: A pad is driven by its data register bit when its direction bit is 1. Reading the data offset returns the data register bit for output pins and the synchronised pad level for input pins.
- R3: With edge-select bit 0 (level mode), the raw status bit follows the synchronised level. With polarity 1 it is set while the pin is high; with polarity 0 it is set while the pin is low. It is not latched.
- R4: With edge-select bit 1 (edge mode), polarity 1 latches the raw status bit on a rising edge and polarity 0 latches it on a falling edge. The bit stays set until it is cleared.
- R5: A write to the end-of-interrupt offset clears the latched edge status of each pin whose data bit is 1. Bits written as 0 are left alone, and level-mode bits are unaffected. If a new edge is detected in the same cycle as the clear, the bit stays set.
- R6: The masked status equals the raw status ANDed with the enable register.
- R7: `irq` is the OR of all masked status bits of both ports. Clearing one port's status leaves `irq` high while the other port still has an enabled pending bit.
- R8: Changing edge-select or polarity while the pin input is stable never latches an edge status bit.
- R9: With a pin's debounce bit set, an input change must persist for DB_CYCLES consecutive clocks before detection sees it. A 2-clock pulse is then ignored and an 8-clock pulse is seen. With the debounce bit clear, a 2-clock pulse is seen.
- R10: `bus_addr[4]` selects port B (1) or port A (0). `bus_addr[3:0]` picks the register: 0 data, 1 direction, 2 edge-select, 3 polarity, 4 end-of-interrupt (reads 0), 5 enable, 6 masked status (read only), 7 raw status (read only), 8 debounce enable. Bit n of each register belongs to pin n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address: port select and offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pa_in | input | 8 | Port A pad inputs |
| pa_out | output | 8 | Port A pad output values |
| pa_oe | output | 8 | Port A pad output enables |
| pb_in | input | 8 | Port B pad inputs |
| pb_out | output | 8 | Port B pad output values |
| pb_oe | output | 8 | Port B pad output enables |
| irq | output | 1 | Combined interrupt of both ports |

## Verification
A freshly detected edge and a software clear of the same status bit can land on one clock edge. If the clear won, that interrupt would be lost. The bench raises a pad at a known point and counts the two synchroniser stages and the detector register. It then times an end-of-interrupt write to commit on exactly the edge where the detector latches. The raw status bit must read 1 afterwards, and a second clear with the pad held steady must then take it to 0.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_OFF_W = 4;
  localparam int BUS_AW    = REG_OFF_W + 1;

  typedef enum logic [REG_OFF_W-1:0] {
    REG_DATA   = 4'h0,
    REG_DIR    = 4'h1,
    REG_EDGE   = 4'h2,
    REG_POL    = 4'h3,
    REG_EOI    = 4'h4,
    REG_EN     = 4'h5,
    REG_MASKED = 4'h6,
    REG_RAW    = 4'h7,
    REG_DEB    = 4'h8
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W      = 8,
  parameter int CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic [CW-1:0] cnt;
    logic          filt;

    // The filtered level flips only after CYCLES consecutive differing samples.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt  <= '0;
        filt <= 1'b0;
      end else if (d[g] == filt) begin
        cnt <= '0;
      end else if (cnt == LAST) begin
        filt <= d[g];
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end

    assign q[g] = filt;
  end
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] det,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] eoi,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev;
  logic [W-1:0] latch_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] hit;
  logic [W-1:0] level;

  always_comb begin
    rise  = det & ~prev;
    fall  = ~det & prev;
    hit   = (pol & rise) | (~pol & fall);
    level = ~(det ^ pol);
  end

  // A new edge outranks a clear in the same cycle; level pins hold no latch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= '0;
      latch_q <= '0;
    end else begin
      prev    <= det;
      latch_q <= edge_sel & (hit | (latch_q & ~eoi));
    end
  end

  assign raw = (edge_sel & latch_q) | (~edge_sel & level);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_irq_pkg::*;
#(
  parameter int W         = 8,
  parameter int DB_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [REG_OFF_W-1:0] reg_off,
  input  logic [W-1:0]         wdata,
  output logic [W-1:0]         rdata,
  input  logic [W-1:0]         pin_in,
  output logic [W-1:0]         pin_out,
  output logic [W-1:0]         pin_oe,
  output logic [W-1:0]         raw_st,
  output logic [W-1:0]         masked_st,
  output logic [W-1:0]         edge_mode,
  output logic [W-1:0]         eoi_stb,
  output logic [W-1:0]         det_val
);
  logic [W-1:0] dout_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] edge_q;
  logic [W-1:0] pol_q;
  logic [W-1:0] en_q;
  logic [W-1:0] deb_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] filt_q;
  reg_sel_e     sel;

  assign sel = reg_sel_e'(reg_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
      deb_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        REG_DATA: dout_q <= wdata;
        REG_DIR:  dir_q  <= wdata;
        REG_EDGE: edge_q <= wdata;
        REG_POL:  pol_q  <= wdata;
        REG_EN:   en_q   <= wdata;
        REG_DEB:  deb_q  <= wdata;
        default:  ;
      endcase
    end
  end

  assign eoi_stb = (wr_en && sel == REG_EOI) ? wdata : '0;

  gpio_sync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (sync_q)
  );

  gpio_debounce #(.W(W), .CYCLES(DB_CYCLES)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (sync_q),
    .q     (filt_q)
  );

  assign det_val = (deb_q & filt_q) | (~deb_q & sync_q);

  gpio_detect #(.W(W)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .det      (det_val),
    .edge_sel (edge_q),
    .pol      (pol_q),
    .eoi      (eoi_stb),
    .raw      (raw_st)
  );

  assign masked_st = raw_st & en_q;
  assign edge_mode = edge_q;
  assign pin_out   = dout_q;
  assign pin_oe    = dir_q;

  always_comb begin
    case (sel)
      REG_DATA:   rdata = (dir_q & dout_q) | (~dir_q & sync_q);
      REG_DIR:    rdata = dir_q;
      REG_EDGE:   rdata = edge_q;
      REG_POL:    rdata = pol_q;
      REG_EN:     rdata = en_q;
      REG_MASKED: rdata = masked_st;
      REG_RAW:    rdata = raw_st;
      REG_DEB:    rdata = deb_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_dual_irq.sv
module gpio_dual_irq
  import gpio_irq_pkg::*;
#(
  parameter int PINS      = 8,
  parameter int DB_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pa_in,
  output logic [PINS-1:0]   pa_out,
  output logic [PINS-1:0]   pa_oe,
  input  logic [PINS-1:0]   pb_in,
  output logic [PINS-1:0]   pb_out,
  output logic [PINS-1:0]   pb_oe,
  output logic              irq
);
  logic                 sel_b;
  logic [REG_OFF_W-1:0] off;
  logic [PINS-1:0] a_rdata, b_rdata;
  logic [PINS-1:0] a_raw, a_masked, a_edge, a_eoi, a_det;
  logic [PINS-1:0] b_raw, b_masked, b_edge, b_eoi, b_det;

  assign sel_b = bus_addr[BUS_AW-1];
  assign off   = bus_addr[REG_OFF_W-1:0];

  gpio_port #(.W(PINS), .DB_CYCLES(DB_CYCLES)) u_port_a (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr & ~sel_b),
    .reg_off   (off),
    .wdata     (bus_wdata),
    .rdata     (a_rdata),
    .pin_in    (pa_in),
    .pin_out   (pa_out),
    .pin_oe    (pa_oe),
    .raw_st    (a_raw),
    .masked_st (a_masked),
    .edge_mode (a_edge),
    .eoi_stb   (a_eoi),
    .det_val   (a_det)
  );

  gpio_port #(.W(PINS), .DB_CYCLES(DB_CYCLES)) u_port_b (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr & sel_b),
    .reg_off   (off),
    .wdata     (bus_wdata),
    .rdata     (b_rdata),
    .pin_in    (pb_in),
    .pin_out   (pb_out),
    .pin_oe    (pb_oe),
    .raw_st    (b_raw),
    .masked_st (b_masked),
    .edge_mode (b_edge),
    .eoi_stb   (b_eoi),
    .det_val   (b_det)
  );

  assign bus_rdata = sel_b ? b_rdata : a_rdata;
  assign irq       = |(a_masked | b_masked);
endmodule

// File: rtl/gpio_dual_irq_chk.sv
module gpio_dual_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      pa_out,
  input logic [W-1:0]      pa_oe,
  input logic [W-1:0]      pb_oe,
  input logic              irq,
  input logic [W-1:0]      a_raw,
  input logic [W-1:0]      a_edge,
  input logic [W-1:0]      a_eoi,
  input logic [W-1:0]      a_det
);
  localparam logic [BUS_AW-1:0] A_DATA = BUS_AW'(REG_DATA);
  localparam logic [BUS_AW-1:0] A_DIR  = BUS_AW'(REG_DIR);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (pa_oe == '0 && pb_oe == '0 && !irq));

  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_DIR) |=> $stable(pa_oe));

  // R2
  out_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_DATA) |=> (pa_out == $past(bus_wdata)));

  // R4
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_eoi == '0) |=>
      (((a_raw | ~a_edge) & $past(a_raw & a_edge)) == $past(a_raw & a_edge)));

  // R8
  edge_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a_raw & a_edge & $past(a_edge) & ~$past(a_raw)) != '0) |->
      ((($past(a_det) ^ $past(a_det, 2)) & a_raw & ~$past(a_raw)) != '0));
endmodule

bind gpio_dual_irq gpio_dual_irq_chk #(.W(PINS)) u_chk (.*);

// File: tb/tb_gpio_dual_irq.sv
`timescale 1ns/1ps
module tb_gpio_dual_irq;
  localparam logic [3:0] O_DATA = 4'h0, O_DIR = 4'h1, O_EDGE = 4'h2, O_POL = 4'h3;
  localparam logic [3:0] O_EOI = 4'h4, O_EN = 4'h5, O_MSK = 4'h6, O_RAW = 4'h7, O_DEB = 4'h8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [4:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
  logic       irq;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_dual_irq dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%02h exp=%02h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] ad(input bit port, input logic [3:0] off);
    return {port, off};
  endfunction

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic setpin(input bit port, input logic [7:0] v);
    @(negedge clk);
    if (port) pb_in = v; else pa_in = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clean(input bit port);
    wr(ad(port, O_EN), 8'h00);
    wr(ad(port, O_EDGE), 8'h00);
    wr(ad(port, O_POL), 8'h00);
    wr(ad(port, O_DEB), 8'h00);
    wr(ad(port, O_EOI), 8'hFF);
  endtask

  // Raw, masked and irq for one swept pin; every other pin is level-low with input 0.
  task automatic look(input bit port, input int pin, input bit expv, input string req);
    logic [7:0] r;
    logic [7:0] m;
    m = 8'h01 << pin;
    rd(ad(port, O_RAW), r);
    chk(req, $sformatf("raw p%0d pin%0d", port, pin), r, ~m | (expv ? m : 8'h00));
    rd(ad(port, O_MSK), r);
    chk("R6", $sformatf("masked p%0d pin%0d", port, pin), r, expv ? m : 8'h00);
    chk("R7", $sformatf("irq p%0d pin%0d", port, pin), {7'b0, irq}, {7'b0, expv});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pa_in = '0; pb_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1", "pa_oe", pa_oe, 8'h00);
    chk("R1", "pb_oe", pb_oe, 8'h00);
    chk("R1", "irq", {7'b0, irq}, 8'h00);
    rd(ad(0, O_RAW), r);  chk("R1", "raw A level-low", r, 8'hFF);
    rd(ad(1, O_RAW), r);  chk("R1", "raw B level-low", r, 8'hFF);
    rd(ad(0, O_EN), r);   chk("R1", "enable A", r, 8'h00);
    rd(ad(1, O_EDGE), r); chk("R1", "edge B", r, 8'h00);

    // R2 / R10 data and direction
    wr(ad(0, O_DIR), 8'hF0); wr(ad(0, O_DATA), 8'hA5);
    wr(ad(1, O_DIR), 8'h0F); wr(ad(1, O_DATA), 8'h3C);
    chk("R2", "pa_out", pa_out, 8'hA5);
    chk("R2", "pa_oe", pa_oe, 8'hF0);
    chk("R10", "pb_out", pb_out, 8'h3C);
    chk("R10", "pb_oe", pb_oe, 8'h0F);
    setpin(0, 8'h3C); setpin(1, 8'hFF); idle(3);
    rd(ad(0, O_DATA), r); chk("R2", "read A data", r, 8'hAC);
    rd(ad(1, O_DATA), r); chk("R2", "read B data", r, 8'hFC);
    rd(ad(0, O_EOI), r);  chk("R10", "eoi reads zero", r, 8'h00);
    wr(ad(1, O_DEB), 8'h5A);
    rd(ad(1, O_DEB), r);  chk("R10", "debounce readback", r, 8'h5A);
    wr(ad(0, O_DIR), 8'h00); wr(ad(1, O_DIR), 8'h00);
    setpin(0, 8'h00); setpin(1, 8'h00);
    clean(0); clean(1); idle(4);

    // R3 R4 R5 R8 sweep over ports, pins and the four detection modes
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 8; i++) begin
        for (int md = 0; md < 4; md++) begin
          logic [7:0] m;
          bit e, pl;
          m  = 8'h01 << i;
          e  = md[1];
          pl = md[0];
          wr(ad(p[0], O_EN), 8'h00);
          wr(ad(p[0], O_EDGE), e ? m : 8'h00);
          wr(ad(p[0], O_POL), pl ? m : 8'h00);
          wr(ad(p[0], O_EN), m);
          idle(2);
          look(p[0], i, e ? 1'b0 : !pl, e ? "R8" : "R3");
          setpin(p[0], m); idle(4);
          look(p[0], i, pl, e ? "R4" : "R3");
          setpin(p[0], 8'h00); idle(4);
          look(p[0], i, e ? 1'b1 : !pl, e ? "R4" : "R3");
          wr(ad(p[0], O_EOI), m); idle(1);
          look(p[0], i, e ? 1'b0 : !pl, "R5");
          wr(ad(p[0], O_EN), 8'h00);
          wr(ad(p[0], O_EOI), 8'hFF);
        end
      end
      clean(p[0]);
    end

    // R8 polarity flip in edge mode with a steady high input
    setpin(0, 8'h01); idle(4);
    wr(ad(0, O_EDGE), 8'h01); wr(ad(0, O_POL), 8'h01);
    wr(ad(0, O_POL), 8'h00); idle(3);
    rd(ad(0, O_RAW), r); chk("R8", "no latch on type change", r & 8'h01, 8'h00);
    setpin(0, 8'h00); clean(0); idle(4);

    // R5 partial clear and R7 shared line
    wr(ad(0, O_EDGE), 8'h0A); wr(ad(0, O_POL), 8'h0A); wr(ad(0, O_EN), 8'h0A);
    wr(ad(1, O_EDGE), 8'h04); wr(ad(1, O_POL), 8'h04); wr(ad(1, O_EN), 8'h04);
    setpin(0, 8'h0A); setpin(1, 8'h04); idle(4);
    setpin(0, 8'h00); setpin(1, 8'h00); idle(4);
    wr(ad(0, O_EOI), 8'h02);
    rd(ad(0, O_MSK), r); chk("R5", "partial clear keeps pin3", r, 8'h08);
    wr(ad(0, O_EOI), 8'h08);
    rd(ad(0, O_MSK), r); chk("R5", "port A cleared", r, 8'h00);
    chk("R7", "irq held by port B", {7'b0, irq}, 8'h01);
    wr(ad(1, O_EN), 8'h00);
    chk("R6", "enable off drops irq", {7'b0, irq}, 8'h00);
    rd(ad(1, O_RAW), r); chk("R6", "raw kept while disabled", r & 8'h04, 8'h04);
    wr(ad(1, O_EOI), 8'h04);
    chk("R7", "irq low after both clear", {7'b0, irq}, 8'h00);
    clean(0); clean(1); idle(4);

    // R5 edge and clear on the same clock edge: the edge wins
    wr(ad(0, O_EDGE), 8'h01); wr(ad(0, O_POL), 8'h01); wr(ad(0, O_EN), 8'h01);
    idle(2);
    setpin(0, 8'h01);
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = ad(0, O_EOI); bus_wdata = 8'h01;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(ad(0, O_RAW), r); chk("R5", "set wins over clear", r & 8'h01, 8'h01);
    wr(ad(0, O_EOI), 8'h01);
    rd(ad(0, O_RAW), r); chk("R5", "later clear", r & 8'h01, 8'h00);
    setpin(0, 8'h00); idle(4);

    // R9 debounce on pin 0 of port A (rising edge mode)
    setpin(0, 8'h01); idle(2); setpin(0, 8'h00); idle(6);
    rd(ad(0, O_RAW), r); chk("R9", "short pulse seen without filter", r & 8'h01, 8'h01);
    wr(ad(0, O_EOI), 8'h01);
    wr(ad(0, O_DEB), 8'h01); idle(6);
    setpin(0, 8'h01); idle(2); setpin(0, 8'h00); idle(10);
    rd(ad(0, O_RAW), r); chk("R9", "short pulse filtered", r & 8'h01, 8'h00);
    setpin(0, 8'h01); idle(8); setpin(0, 8'h00); idle(10);
    rd(ad(0, O_RAW), r); chk("R9", "long pulse passes filter", r & 8'h01, 8'h01);
    clean(0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule